// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with built-in burst addressing. Each word is 18 bits wide and made of two 9-bit byte lanes. The depth is a parameter, with a 64-word default for simulation. Every control and data input is captured on the rising clock edge.

A burst is opened by either of two address strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, as the write controls select. After that, cycles with no strobe either step a two-bit wrapping burst counter or repeat the current location. Read data passes through an output register. When the part is deselected, the output stays valid for one extra cycle before it drops. This lets two banks share a read bus with no dead cycle between them.

The read side is a stream producer that has only a valid flag, `rd_valid`. It has no ready input and cannot be stalled. A consumer that cannot accept a word must hold the strobes and the advance input so that the model repeats the same location. The output enable `out_en_n` masks the valid flag and the data combinationally. It does not disturb the pipeline.

Top module: `burst_sram`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0.
- R2: A selected read sampled at clock edge k shows no new data after edge k. After edge k+1, `rd_valid` is 1 and `rd_data` holds the stored word.
- R3: When `strb_cpu_n` is low at an edge, the cycle is a read. All write controls are ignored, even when `strb_ctl_n` is low in the same cycle. The memory is left unchanged.
- R4: With `strb_ctl_n` low and `all_wr_n` low, both lanes are written with `wr_data`, whatever `lane_we_n` and `lane_wr_en_n` hold.
- R5: With `all_wr_n` high and `lane_wr_en_n` low, lane i (bits 9i+8..9i, so lane 0 is bits 8..0) is written exactly when `lane_we_n[i]` is 0. With `lane_wr_en_n` high, `lane_we_n` writes nothing.
- R6: In a no-strobe cycle of an open burst with `step_n` low, the low two address bits advance by one and wrap modulo 4. The upper address bits stay fixed.
- R7: In a no-strobe cycle of an open burst with `step_n` high, the same location is accessed again.
- R8: `addr` is loaded only at an edge where a strobe is low. At all other edges it is ignored.
- R9: A strobe opens a burst only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination at a strobe closes the burst. No-strobe cycles that follow then neither read nor write.
- R10: A deselect sampled at edge k, after a read sampled at edge k-1, keeps `rd_valid` high with the same data after edges k and k+1. `rd_valid` drops after edge k+2.
- R11: `out_en_n` high forces `rd_valid` and `rd_data` to 0 at once, with no clock. Lowering it shows the registered data again.
- R12: One edge after a write is sampled, `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address, loaded at a strobe |
| wr_data | input | 18 | Write data |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, read only |
| strb_ctl_n | input | 1 | Controller-side address strobe |
| step_n | input | 1 | Burst advance, active low |
| lane_we_n | input | 2 | Per-lane write enables, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane write controls |
| all_wr_n | input | 1 | Writes every lane, active low |
| out_en_n | input | 1 | Combinational output mask, active low |
| rd_data | output | 18 | Registered read data, masked |
| rd_valid | output | 1 | Read data valid, masked |

## Verification
The bench first fills the whole array. It then reads every location back through the processor strobe while driving write controls. A design that let those controls through would drop `rd_valid` or corrupt the next sweep. Bursts start from bases spread across every low-bit phase and step five times. A counter that carried into the upper bits, or did not wrap, would return a neighbouring block's word.

All eight select combinations are tried, each followed by a strobe-less write. A lax decode, or a burst left open after a deselect, would overwrite the probe word. The deselect tail is sampled on both sides of the extra cycle. A single-stage turn-off would drop `rd_valid` one edge early, and a missing turn-off would never drop it.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             step_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             lane_wr_en_n,
  input  logic             all_wr_n,
  input  logic             open_q,
  output logic             load,
  output logic             kill,
  output logic             adv,
  output sram_op_e         op,
  output logic [LANES-1:0] lanes
);
  logic             strobe;
  logic             chosen;
  logic [LANES-1:0] req_lanes;

  assign strobe = ~strb_cpu_n | ~strb_ctl_n;
  assign chosen = ~sel_a_n & sel_b & ~sel_c_n;

  // global write beats the per-lane enables
  always_comb begin
    if (!all_wr_n)          req_lanes = '1;
    else if (!lane_wr_en_n) req_lanes = ~lane_we_n;
    else                    req_lanes = '0;
  end

  always_comb begin
    load = strobe & chosen;
    kill = strobe & ~chosen;
    adv  = ~strobe & open_q & ~step_n;
    op   = OP_IDLE;
    if (strobe) begin
      if (chosen) begin
        if (!strb_cpu_n)     op = OP_READ;   // processor strobe never writes
        else if (|req_lanes) op = OP_WRITE;
        else                 op = OP_READ;
      end
    end else if (open_q) begin
      op = (|req_lanes) ? OP_WRITE : OP_READ;
    end
    lanes = (op == OP_WRITE) ? req_lanes : '0;
  end
endmodule

// File: rtl/burst_sram_addr.sv
module burst_sram_addr #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          kill,
  input  logic          adv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_q,
  output logic          open_q
);
  localparam logic [BB-1:0] STEP = BB'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      open_q <= 1'b0;
    end else if (load) begin
      cur_q  <= addr_in;
      open_q <= 1'b1;
    end else if (kill) begin
      open_q <= 1'b0;
    end else if (adv) begin
      cur_q[BB-1:0] <= cur_q[BB-1:0] + STEP;  // wraps inside the burst block
    end
  end

  p_adv_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !kill) |=> (cur_q[AW-1:BB] == $past(cur_q[AW-1:BB])));

  p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(cur_q));
endmodule

// File: rtl/burst_sram_store.sv
module burst_sram_store
  import burst_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sram_op_e            op,
  input  logic [LANES-1:0]    lanes,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata_q,
  output logic                dval_q
);
  localparam int DEPTH = 1 << AW;
  localparam int W     = LANES * LW;

  logic [W-1:0] mem [DEPTH];
  logic         linger_q;  // second deselect stage

  always_ff @(posedge clk) begin
    if (op == OP_WRITE) begin
      for (int g = 0; g < LANES; g++) begin
        if (lanes[g]) mem[addr][g*LW +: LW] <= wdata[g*LW +: LW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      dval_q   <= 1'b0;
      linger_q <= 1'b0;
    end else begin
      case (op)
        OP_READ: begin
          rdata_q  <= mem[addr];
          dval_q   <= 1'b1;
          linger_q <= 1'b1;
        end
        OP_WRITE: begin
          dval_q   <= 1'b0;
          linger_q <= 1'b1;
        end
        default: begin
          dval_q   <= dval_q & linger_q;
          linger_q <= 1'b0;
        end
      endcase
    end
  end

  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |=> dval_q);

  p_write_blank_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> !dval_q);

  p_desel_linger_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE && $past(op) == OP_READ) |=> dval_q);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9,
  parameter int BB    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                strb_cpu_n,
  input  logic                strb_ctl_n,
  input  logic                step_n,
  input  logic [LANES-1:0]    lane_we_n,
  input  logic                lane_wr_en_n,
  input  logic                all_wr_n,
  input  logic                out_en_n,
  output logic [LANES*LW-1:0] rd_data,
  output logic                rd_valid
);
  localparam int W = LANES * LW;

  logic             load, kill, adv, open_q;
  sram_op_e         op_d, s1_op;
  logic [LANES-1:0] lanes_d, s1_lanes;
  logic [W-1:0]     s1_data, rdata_q;
  logic [AW-1:0]    cur_q;
  logic             dval_q;

  burst_sram_decode #(.LANES(LANES)) u_decode (
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .step_n(step_n), .lane_we_n(lane_we_n), .lane_wr_en_n(lane_wr_en_n),
    .all_wr_n(all_wr_n), .open_q(open_q),
    .load(load), .kill(kill), .adv(adv), .op(op_d), .lanes(lanes_d)
  );

  burst_sram_addr #(.AW(AW), .BB(BB)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .kill(kill), .adv(adv),
    .addr_in(addr), .cur_q(cur_q), .open_q(open_q)
  );

  // input stage: command, lanes and data registered with the address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op    <= OP_IDLE;
      s1_lanes <= '0;
      s1_data  <= '0;
    end else begin
      s1_op    <= op_d;
      s1_lanes <= lanes_d;
      s1_data  <= wr_data;
    end
  end

  burst_sram_store #(.AW(AW), .LANES(LANES), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .op(s1_op), .lanes(s1_lanes),
    .addr(cur_q), .wdata(s1_data), .rdata_q(rdata_q), .dval_q(dval_q)
  );

  assign rd_data  = out_en_n ? '0 : rdata_q;
  assign rd_valid = dval_q & ~out_en_n;

  p_cpu_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !sel_a_n && sel_b && !sel_c_n) |=> (s1_op == OP_READ));

  p_desel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strb_cpu_n || !strb_ctl_n) && (sel_a_n || !sel_b || sel_c_n)) |=> (s1_op == OP_IDLE));
endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/100ps
module burst_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic [17:0] wr_data;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        strb_cpu_n, strb_ctl_n, step_n;
  logic [1:0]  lane_we_n;
  logic        lane_wr_en_n, all_wr_n, out_en_n;
  logic [17:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int failures = 0;
  logic [17:0] shadow [64];

  always #2 clk = ~clk;

  burst_sram u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
    .lane_we_n(lane_we_n), .lane_wr_en_n(lane_wr_en_n), .all_wr_n(all_wr_n),
    .out_en_n(out_en_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [17:0] pat(input int n);
    return 18'((n * 1237 + 91) ^ (n << 11));
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drv_idle();
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_we_n = 2'b11;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; out_en_n = 1'b0;
  endtask

  task automatic deselect();
    drv_idle();
    sel_a_n = 1'b1; strb_ctl_n = 1'b0;
    tick();
    drv_idle();
    tick();
    tick();
  endtask

  task automatic ctl_read(input int a);
    drv_idle();
    strb_ctl_n = 1'b0; addr = 6'(a);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    drv_idle();
    addr = '0; wr_data = '0; rst_n = 1'b0;
    tick(); tick(); tick();
    chk("R1 valid", {17'b0, rd_valid}, 18'd0);
    chk("R1 data", rd_data, 18'd0);
    rst_n = 1'b1;
    tick();

    // fill every word with the global write (R4); R12 blanking after each write
    for (int a = 0; a <= 64; a++) begin
      drv_idle();
      if (a < 64) begin
        strb_ctl_n = 1'b0; addr = 6'(a); all_wr_n = 1'b0;
        lane_wr_en_n = 1'b0; lane_we_n = 2'b11;
        wr_data = pat(a); shadow[a] = pat(a);
      end
      tick();
      if (a > 0) chk("R12 valid after write", {17'b0, rd_valid}, 18'd0);
    end
    deselect();

    // processor strobe reads with write controls active (R3), both strobes on odd
    for (int a = 0; a <= 64; a++) begin
      drv_idle();
      if (a < 64) begin
        strb_cpu_n = 1'b0; strb_ctl_n = a[0] ? 1'b0 : 1'b1;
        addr = 6'(a); all_wr_n = 1'b0; wr_data = ~pat(a);
      end
      tick();
      if (a > 0) begin
        chk("R3 valid", {17'b0, rd_valid}, 18'd1);
        chk("R3 data", rd_data, shadow[a-1]);
      end
    end
    deselect();

    // controller read sweep: memory untouched by the previous pass (R3, R4)
    for (int a = 0; a <= 64; a++) begin
      drv_idle();
      if (a < 64) ctl_read(a);
      tick();
      if (a > 0) chk("R4 readback", rd_data, shadow[a-1]);
    end
    deselect();

    // per-lane writes, all four masks (R5)
    for (int a = 0; a < 8; a++) begin
      for (int m = 0; m < 4; m++) begin
        drv_idle();
        strb_ctl_n = 1'b0; addr = 6'(a); lane_wr_en_n = 1'b0;
        lane_we_n = 2'(m); wr_data = pat(a + m * 8 + 100);
        if (!m[0]) shadow[a][8:0]  = wr_data[8:0];
        if (!m[1]) shadow[a][17:9] = wr_data[17:9];
        tick();
      end
    end
    for (int a = 8; a < 12; a++) begin
      drv_idle();
      strb_ctl_n = 1'b0; addr = 6'(a); lane_wr_en_n = 1'b1;
      lane_we_n = 2'b00; wr_data = pat(a + 500);
      tick();
    end
    deselect();
    for (int a = 0; a <= 12; a++) begin
      drv_idle();
      if (a < 12) ctl_read(a);
      tick();
      if (a > 0) chk("R5 lane readback", rd_data, shadow[a-1]);
    end
    deselect();

    // bursts with wrap (R6)
    for (int b = 0; b < 64; b += 9) begin
      ctl_read(b);
      tick();
      for (int s = 1; s <= 5; s++) begin
        drv_idle();
        step_n = (s < 5) ? 1'b0 : 1'b1;
        addr = 6'(b + 17);
        tick();
        chk("R6 burst", rd_data, shadow[{6'(b) >> 2, 2'(b + s - 1)}]);
      end
      deselect();
    end

    // suspend with a changing address input (R7, R8)
    ctl_read(33);
    tick();
    for (int i = 0; i < 4; i++) begin
      drv_idle();
      addr = 6'(34 + i);
      tick();
      chk("R7 R8 suspend", rd_data, shadow[33]);
    end
    deselect();

    // select decode (R9)
    for (int s = 0; s < 8; s++) begin
      drv_idle();
      {sel_a_n, sel_b, sel_c_n} = 3'(s);
      strb_ctl_n = 1'b0; addr = 6'd60; all_wr_n = 1'b0; wr_data = pat(200 + s);
      tick();
      drv_idle();
      all_wr_n = 1'b0;
      tick();
      if (s == 2) shadow[60] = pat(200 + s);
      deselect();
      ctl_read(60);
      tick();
      drv_idle();
      tick();
      chk("R9 select", rd_data, shadow[60]);
      deselect();
    end

    // latency (R2) and two-cycle deselect (R10)
    ctl_read(20);
    tick();
    chk("R2 not yet valid", {17'b0, rd_valid}, 18'd0);
    drv_idle();
    sel_a_n = 1'b1; strb_ctl_n = 1'b0;
    tick();
    chk("R2 valid", {17'b0, rd_valid}, 18'd1);
    chk("R2 data", rd_data, shadow[20]);
    drv_idle();
    tick();
    chk("R10 held valid", {17'b0, rd_valid}, 18'd1);
    chk("R10 held data", rd_data, shadow[20]);
    tick();
    chk("R10 released", {17'b0, rd_valid}, 18'd0);

    // output mask (R11)
    ctl_read(40);
    tick();
    drv_idle();
    tick();
    out_en_n = 1'b1;
    #0.5;
    chk("R11 masked valid", {17'b0, rd_valid}, 18'd0);
    chk("R11 masked data", rd_data, 18'd0);
    out_en_n = 1'b0;
    #0.5;
    chk("R11 unmasked valid", {17'b0, rd_valid}, 18'd1);
    chk("R11 unmasked data", rd_data, shadow[40]);
    deselect();

    summary();
  end
endmodule